// File: doc/BRIEF.md
# Dual-Stream Token Copier

The block fans result tokens out to four output channels: north, east, south and west. It has two independent copy streams, A and B. Every channel in and out is a dual-rail four-phase handshake, modelled on a clock. For a data channel, the sender raises exactly one of two rails. The receiver answers by lowering its enable. The sender then returns both rails to zero, and the receiver raises its enable again when it can take more.

A static configuration gives each output port to stream A, to stream B, or to neither. A stream accepts a token from its input and puts a fresh copy on every port it owns. Each port's receiver completes its handshake on its own schedule. The stream acknowledges its input only once every owned port has taken the copy.

The two streams share no state apart from the configuration. A stalled receiver on one stream therefore never holds up the other. A port claimed by both streams is reported as a configuration error, and neither stream drives it.

Top module: `token_copier`

## Requirements
- R1: After reset both input enables are high, all output rails are 00 and the error flag is low.
- R2: A rail pair is read with bit 0 as the zero-rail and bit 1 as the one-rail: 01 carries value 0, 10 carries value 1, 00 means no token. An input pair of 11 is ignored: nothing reaches any port and the enable stays high.
- R3: Port index 0..3 stands for north, east, south and west. Setting cfg_a_i[p] alone gives port p to stream A, and setting cfg_b_i[p] alone gives it to stream B. Each accepted token appears on every port of its stream.
- R4: An input enable falls only after the receiver of every port owned by that stream has lowered its enable. It rises again once the input rails have returned to 00.
- R5: A port holds its rails until its own receiver lowers the enable. It then returns them to 00 at once, without waiting for the other ports.
- R6: A port starts a new token only while its receiver's enable is high. A stream starts a token only when all of its ports are ready.
- R7: The streams run independently: a receiver that never acknowledges on stream A does not stop stream B from completing tokens.
- R8: When a port is set in both cfg_a_i and cfg_b_i, cfg_err_o goes high one cycle later. That port is then driven by neither stream, and the other ports keep their assignment.
- R9: A stream that owns no port never acknowledges its input: its enable stays high.
- R10: Every owned port receives exactly the input token sequence of its stream, in order, with no loss and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_a_i | input | 4 | Ports owned by stream A, bit per port |
| cfg_b_i | input | 4 | Ports owned by stream B, bit per port |
| a_rail_i | input | 2 | Stream A input rails |
| a_en_o | output | 1 | Stream A input enable (low = acknowledged) |
| b_rail_i | input | 2 | Stream B input rails |
| b_en_o | output | 1 | Stream B input enable (low = acknowledged) |
| out_rail_o | output | 8 | Output rails, port p at bits 2p+1:2p |
| out_en_i | input | 4 | Receiver enables, one per port |
| cfg_err_o | output | 1 | Port claimed by both streams |

## Verification
The assertions assume senders and receivers that obey the handshake. A sender keeps its rails valid until the enable falls and never drives 11 while it is waiting for an acknowledge. A receiver lowers its enable only while it sees a token. The configuration is assumed to change only while both streams and all receivers are at rest. The stimulus meets these rules: configuration is written only between test phases, after every enable has returned high. The bench receivers lower and raise their enables after independent random delays and react only to valid rails. The one deliberate 11 pattern is applied while the stream is idle, and its only purpose is to show that it is ignored.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    localparam int unsigned RAIL_W  = 2;
    localparam int unsigned NSTREAM = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RTZ  = 2'd2
    } cp_state_e;

    // exactly one rail high means a token is present
    function automatic logic rail_valid(input logic [RAIL_W-1:0] r);
        return r[0] ^ r[1];
    endfunction

    function automatic logic [RAIL_W-1:0] rail_enc(input logic v, input logic live);
        if (!live) return '0;
        return v ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/tcp_copy_stream.sv
module tcp_copy_stream
    import tcp_pkg::*;
#(
    parameter int unsigned NPORT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPORT-1:0]  mask_i,
    input  logic [RAIL_W-1:0] rail_i,
    input  logic [NPORT-1:0]  port_en_i,
    output logic              en_o,
    output logic              tok_o,
    output logic [NPORT-1:0]  pend_o
);

    typedef struct packed {
        cp_state_e        st;
        logic             tok;
        logic [NPORT-1:0] pend;
    } cp_regs_t;

    cp_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (rail_valid(rail_i) && (mask_i != '0) &&
                    ((port_en_i & mask_i) == mask_i)) begin
                    regs_d.tok  = rail_i[1];
                    regs_d.pend = mask_i;
                    regs_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                // a port leaves the pending set once its receiver acks
                regs_d.pend = regs_q.pend & port_en_i;
                if (regs_d.pend == '0) regs_d.st = ST_RTZ;
            end
            ST_RTZ: begin
                if (rail_i == '0) regs_d.st = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '{st: ST_IDLE, tok: 1'b0, pend: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o   = (regs_q.st != ST_RTZ);
    assign tok_o  = regs_q.tok;
    assign pend_o = regs_q.pend;

    // R9: a stream with no port never acknowledges
    a_r9_empty_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |-> en_o);

    // R10: while sending, no port is re-armed with a second copy
    a_r10_no_resend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.st == ST_SEND) |=> ((regs_q.pend & ~$past(regs_q.pend)) == '0));

endmodule

// File: rtl/tcp_port_drive.sv
module tcp_port_drive
    import tcp_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NSTREAM-1:0] sel_i,
    input  logic [NSTREAM-1:0] tok_i,
    input  logic [NSTREAM-1:0] pend_i,
    input  logic               en_i,
    output logic [RAIL_W-1:0]  rail_o
);

    always_comb begin
        rail_o = '0;
        for (int s = 0; s < NSTREAM; s++) begin
            if (sel_i[s]) rail_o = rail_enc(tok_i[s], pend_i[s]);
        end
    end

    // R2: the two rails are never high together
    a_r2_rail_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rail_o != 2'b11);

    // R5: a token stays on the port until its receiver acknowledges
    a_r5_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rail_o != '0) && en_i) |=> (rail_o == $past(rail_o)));

    // R6: a token only appears while the receiver was ready
    a_r6_start_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rail_o != '0) && ($past(rail_o) == '0)) |-> $past(en_i));

endmodule

// File: rtl/token_copier.sv
module token_copier
    import tcp_pkg::*;
#(
    parameter int unsigned NPORT = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NPORT-1:0]          cfg_a_i,
    input  logic [NPORT-1:0]          cfg_b_i,
    input  logic [RAIL_W-1:0]         a_rail_i,
    output logic                      a_en_o,
    input  logic [RAIL_W-1:0]         b_rail_i,
    output logic                      b_en_o,
    output logic [RAIL_W*NPORT-1:0]   out_rail_o,
    input  logic [NPORT-1:0]          out_en_i,
    output logic                      cfg_err_o
);

    localparam int unsigned OUT_W = RAIL_W * NPORT;

    logic [NPORT-1:0]  conflict;
    logic [NPORT-1:0]  own   [NSTREAM];
    logic [RAIL_W-1:0] src   [NSTREAM];
    logic [NPORT-1:0]  pend  [NSTREAM];
    logic [NSTREAM-1:0] s_en;
    logic [NSTREAM-1:0] s_tok;
    logic [NPORT-1:0]  busy;
    logic              err_d, err_q;

    // a port claimed twice is given to nobody
    assign conflict = cfg_a_i & cfg_b_i;
    assign own[0]   = cfg_a_i & ~conflict;
    assign own[1]   = cfg_b_i & ~conflict;
    assign src[0]   = a_rail_i;
    assign src[1]   = b_rail_i;

    generate
        for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
            tcp_copy_stream #(.NPORT(NPORT)) stream_i (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .mask_i    (own[s]),
                .rail_i    (src[s]),
                .port_en_i (out_en_i),
                .en_o      (s_en[s]),
                .tok_o     (s_tok[s]),
                .pend_o    (pend[s])
            );

            // R4: input ack only when every owned port has gone quiet
            a_r4_ack_after_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !s_en[s] |-> ((busy & own[s]) == '0));
        end

        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic [NSTREAM-1:0] sel_p, pend_p;
            for (genvar s = 0; s < NSTREAM; s++) begin : g_bit
                assign sel_p[s]  = own[s][p];
                assign pend_p[s] = pend[s][p];
            end
            tcp_port_drive drive_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .sel_i  (sel_p),
                .tok_i  (s_tok),
                .pend_i (pend_p),
                .en_i   (out_en_i[p]),
                .rail_o (out_rail_o[RAIL_W*p +: RAIL_W])
            );
            assign busy[p] = |out_rail_o[RAIL_W*p +: RAIL_W];
        end
    endgenerate

    always_comb begin
        err_d = |conflict;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= err_d;
    end

    assign a_en_o    = s_en[0];
    assign b_en_o    = s_en[1];
    assign cfg_err_o = err_q;

    // R8: a shared claim raises the flag on the next cycle
    a_r8_conflict_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(cfg_a_i & cfg_b_i)) |=> cfg_err_o);

    // R8: no port ever has a pending copy from both streams
    a_r8_single_sender: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend[0] & pend[1]) == '0);

    initial begin
        assert (OUT_W == RAIL_W * NPORT);
    end

endmodule

// File: tb/token_copier_tb_top.sv
module token_copier_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_a = '0, cfg_b = '0;
    logic [1:0] a_rail = '0, b_rail = '0;
    logic       a_en, b_en, err;
    logic [7:0] out_rail;
    logic [3:0] out_en = 4'hF;
    logic [3:0] stall = '0;

    int checks = 0;
    int errors = 0;
    int cnt [4] = '{default: 0};
    int dly [4] = '{default: 0};
    int base [4];
    int viol_r6 = 0;
    logic [1:0] prev_rail [4] = '{default: 2'b00};
    logic log_m [4][256];

    always #4 clk = ~clk;

    token_copier dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_a_i(cfg_a), .cfg_b_i(cfg_b),
        .a_rail_i(a_rail), .a_en_o(a_en), .b_rail_i(b_rail), .b_en_o(b_en),
        .out_rail_o(out_rail), .out_en_i(out_en), .cfg_err_o(err)
    );

    // receivers: independent random delays per port
    always @(negedge clk) begin
        for (int p = 0; p < 4; p++) begin
            logic [1:0] r;
            r = out_rail[2*p +: 2];
            if (r != 2'b00 && prev_rail[p] == 2'b00 && !out_en[p]) viol_r6++;
            prev_rail[p] = r;
            if (out_en[p]) begin
                if ((r == 2'b01 || r == 2'b10) && !stall[p]) begin
                    if (dly[p] == 0) begin
                        if (cnt[p] < 256) log_m[p][cnt[p]] = r[1];
                        cnt[p]++;
                        out_en[p] = 1'b0;
                        dly[p] = int'($urandom_range(3, 0));
                    end else dly[p]--;
                end
            end else if (r == 2'b00) begin
                if (dly[p] == 0) begin
                    out_en[p] = 1'b1;
                    dly[p] = int'($urandom_range(3, 0));
                end else dly[p]--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic cur_en(input int s);
        return (s == 0) ? a_en : b_en;
    endfunction

    task automatic set_rail(input int s, input logic [1:0] v);
        if (s == 0) a_rail = v; else b_rail = v;
    endtask

    task automatic send_tok(input int s, input bit v, input int k, input logic [3:0] m);
        set_rail(s, v ? 2'b10 : 2'b01);
        do @(negedge clk); while (cur_en(s));
        for (int p = 0; p < 4; p++) begin
            if (m[p]) chk(cnt[p] - base[p] >= k + 1, "R4 ack before all ports took token",
                          cnt[p] - base[p], k + 1);
        end
        set_rail(s, 2'b00);
        do @(negedge clk); while (!cur_en(s));
    endtask

    task automatic send_seq(input int s, input logic [7:0] seq, input logic [3:0] m);
        for (int k = 0; k < 8; k++) send_tok(s, seq[k], k, m);
    endtask

    task automatic snap();
        for (int p = 0; p < 4; p++) base[p] = cnt[p];
    endtask

    // {cfg_a, cfg_b, tokens A (bit0 first), tokens B}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        {4'b1111, 4'b0000, 8'b1011_0010, 8'h00},
        {4'b0000, 4'b1111, 8'h00,        8'b0110_1101},
        {4'b0101, 4'b1010, 8'b1100_1010, 8'b0011_0101},
        {4'b0001, 4'b1110, 8'b1111_0000, 8'b1001_0110},
        {4'b0111, 4'b1000, 8'b0101_0101, 8'b1110_0011},
        {4'b0011, 4'b0110, 8'b1000_1101, 8'b0111_1000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(a_en && b_en, "R1 input enables after reset", {a_en, b_en}, 3);
        chk(out_rail == 8'h00, "R1 output rails after reset", out_rail, 0);
        chk(!err, "R1 error flag after reset", err, 0);

        // table walk: R3, R10, R8
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] ma, mb;
            logic [7:0] sa, sb;
            cfg_a = VEC[v][23:20];
            cfg_b = VEC[v][19:16];
            sa = VEC[v][15:8];
            sb = VEC[v][7:0];
            ma = cfg_a & ~cfg_b;
            mb = cfg_b & ~cfg_a;
            repeat (2) @(negedge clk);
            chk(err == |(cfg_a & cfg_b), "R8 conflict flag", err, |(cfg_a & cfg_b));
            snap();
            fork
                begin if (ma != 0) send_seq(0, sa, ma); end
                begin if (mb != 0) send_seq(1, sb, mb); end
            join
            repeat (12) @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                int n, exp_n, bad;
                logic [7:0] sq;
                n = cnt[p] - base[p];
                exp_n = (ma[p] || mb[p]) ? 8 : 0;
                sq = ma[p] ? sa : sb;
                bad = 0;
                if (n == exp_n) begin
                    for (int k = 0; k < exp_n; k++)
                        if (log_m[p][base[p] + k] != sq[k]) bad++;
                end
                if (cfg_a[p] && cfg_b[p])
                    chk(n == 0, "R8 conflicting port stays silent", n, 0);
                else
                    chk(n == exp_n && bad == 0, "R3/R10 port token count and order",
                        n * 100 + bad, exp_n * 100);
            end
        end
        cfg_a = '0; cfg_b = '0;
        repeat (4) @(negedge clk);
        chk(!err, "R8 flag clears without conflict", err, 0);

        // R2: the 11 pattern is ignored
        cfg_a = 4'b1111;
        repeat (2) @(negedge clk);
        snap();
        a_rail = 2'b11;
        begin
            int bad2;
            bad2 = 0;
            repeat (12) begin
                @(negedge clk);
                if (!a_en || out_rail != 8'h00) bad2++;
            end
            chk(bad2 == 0, "R2 illegal code 11 ignored", bad2, 0);
        end
        a_rail = 2'b00;
        repeat (2) @(negedge clk);

        // R9: stream with no ports never acknowledges
        cfg_a = 4'b0001; cfg_b = 4'b0000;
        repeat (2) @(negedge clk);
        b_rail = 2'b01;
        begin
            int bad3;
            bad3 = 0;
            repeat (20) begin
                @(negedge clk);
                if (!b_en || out_rail[7:2] != 6'd0) bad3++;
            end
            chk(bad3 == 0, "R9 empty stream not acknowledged", bad3, 0);
        end
        b_rail = 2'b00;
        repeat (2) @(negedge clk);

        // R7: stalled stream A does not block stream B
        cfg_a = 4'b0001; cfg_b = 4'b1110;
        repeat (2) @(negedge clk);
        snap();
        stall[0] = 1'b1;
        a_rail = 2'b10;
        for (int k = 0; k < 4; k++) send_tok(1, k[0], k, 4'b1110);
        repeat (8) @(negedge clk);
        for (int p = 1; p < 4; p++)
            chk(cnt[p] - base[p] == 4, "R7 stream B progresses while A stalls",
                cnt[p] - base[p], 4);
        chk(a_en == 1'b1, "R4 stalled stream not acknowledged", a_en, 1);
        chk(out_rail[1:0] == 2'b10, "R5 stalled port holds its token", out_rail[1:0], 2);
        stall[0] = 1'b0;
        while (a_en) @(negedge clk);
        a_rail = 2'b00;
        while (!a_en) @(negedge clk);
        chk(cnt[0] - base[0] == 1 && log_m[0][base[0]] == 1'b1,
            "R10 released port got its single token", cnt[0] - base[0], 1);
        repeat (8) @(negedge clk);
        chk(viol_r6 == 0, "R6 token started while receiver not ready", viol_r6, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule